// File: doc/BRIEF.md
# Reference Switch Phase Build-Out Unit

This unit keeps a reference switch from showing up as a phase step at the input of a digital phase-locked loop. It runs on a fast sampling clock. Both the reference and the loop feedback arrive as one-cycle edge pulses. On every reference edge it counts the fast-clock cycles until the next feedback edge, and it keeps the latest completed count. When a switch strobe arrives and compensation is enabled, the next reference edge copies that count into an offset register. From then on, every reference edge is followed by a one-cycle virtual reference pulse that is delayed by the stored offset. The loop therefore keeps seeing the phase relation it had before the switch.

While compensation is disabled, the stored offset decays toward zero by a bounded step on each tick of an internal slew tick generator. The output then drifts back into alignment with the live reference at a limited rate. An active-low clear input zeroes the offset, but only after it has been held low for a minimum number of clock cycles. Shorter glitches on the clear input are ignored.

Top module: `phase_buildout`

## Requirements
- R1: A measurement is the number of clock cycles from the cycle in which `ref_edge_i` is high to the first later cycle in which `fb_edge_i` is high. The most recent completed measurement is the value that a capture loads.
- R2: After a `switch_i` pulse, only the first following reference edge can load the measurement into `offset_o`. Later reference edges with no new switch pulse leave `offset_o` unchanged.
- R3: If `enable_i` is low in the cycle of that first reference edge, no load takes place and the pending switch is consumed.
- R4: Every reference edge produces exactly one `vref_o` pulse, one cycle wide. It is visible in the cycle that comes D+1 cycles after the reference edge cycle, where D is the offset in effect after that edge.
- R5: When `clr_ni` has been sampled low for CLR_MIN_CYC consecutive clock edges, `offset_o` becomes 0. A low period shorter than that has no effect.
- R6: While `enable_i` is low, each slew tick lowers `offset_o` by SLEW_STEP, stopping at 0. Slew ticks occur exactly once every TICK_CYC clock cycles.
- R7: While `enable_i` is high and no load or clear occurs, `offset_o` holds its value indefinitely.
- R8: After reset, `offset_o` is 0 and `vref_o` is low.
- R9: A feedback edge in the same cycle as the reference edge measures 0. Counts saturate at 2^PH_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_edge_i | input | 1 | One-cycle pulse on each selected-reference edge |
| fb_edge_i | input | 1 | One-cycle pulse on each feedback edge |
| switch_i | input | 1 | One-cycle strobe marking a reference switch |
| enable_i | input | 1 | High enables offset capture; low enables slew decay |
| clr_ni | input | 1 | Active-low clear request, filtered for minimum width |
| vref_o | output | 1 | Virtual reference pulse |
| offset_o | output | PH_W | Stored phase offset in clock cycles |

## Verification
A table of reference-to-feedback spacings is walked, each followed by a switch and a capture. The spacings are coincident, one cycle, mid-range, and beyond the counter range, so the zero case and saturation can each be told apart from ordinary counting. Each capture is also checked for where its virtual pulse lands, which confirms that the delay uses the newly loaded value. One entry switches with enable low, which separates a consumed switch from a load. Directed runs then cover the following: a reference edge with no switch, a clear one cycle too short against one of exact length, decay over an exact number of tick periods including the floor at zero, and a long hold with enable high.

// File: rtl/phase_buildout_pkg.sv
package phase_buildout_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_CLEAR   = 2'd1,
    UPD_CAPTURE = 2'd2,
    UPD_SLEW    = 2'd3
  } upd_sel_e;
endpackage

// File: rtl/pb_phase_meter.sv
module pb_phase_meter #(
  parameter int PH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_edge_i,
  input  logic            fb_edge_i,
  output logic [PH_W-1:0] meas_o
);
  localparam logic [PH_W-1:0] CNT_MAX = '1;

  logic [PH_W-1:0] cnt_q, meas_q;
  logic            run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      meas_q <= '0;
      run_q  <= 1'b0;
    end else if (ref_edge_i) begin
      cnt_q <= PH_W'(1);
      run_q <= !fb_edge_i;
      if (fb_edge_i) meas_q <= '0;
    end else if (run_q && fb_edge_i) begin
      meas_q <= cnt_q;
      run_q  <= 1'b0;
    end else if (run_q && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + PH_W'(1);
    end
  end

  assign meas_o = meas_q;

  AST_MEAS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_edge_i && fb_edge_i) |=> meas_o == '0); // R9
endmodule

// File: rtl/pb_clear_filter.sv
module pb_clear_filter #(
  parameter int MIN_CYC = 38
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic hit_o
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] low_q;

  // fires once, on the MIN_CYC-th consecutive low sample
  assign hit_o = !clr_ni && (low_q == CW'(MIN_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  low_q <= '0;
    else if (clr_ni)              low_q <= '0;
    else if (low_q != CW'(MIN_CYC)) low_q <= low_q + CW'(1);
  end

  AST_CLEAR_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o); // R5
endmodule

// File: rtl/pb_tick_gen.sv
module pb_tick_gen #(
  parameter int PERIOD = 15625
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PERIOD > 1 && tick_o) |=> !tick_o); // R6
endmodule

// File: rtl/pb_vref_delay.sv
module pb_vref_delay #(
  parameter int PH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_edge_i,
  input  logic [PH_W-1:0] delay_i,
  output logic            vref_o
);
  logic [PH_W-1:0] rem_q;
  logic            act_q, vref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      act_q  <= 1'b0;
      vref_q <= 1'b0;
    end else begin
      vref_q <= 1'b0;
      if (ref_edge_i) begin
        // a new edge restarts the delay
        if (delay_i == '0) begin
          vref_q <= 1'b1;
          act_q  <= 1'b0;
        end else begin
          rem_q <= delay_i;
          act_q <= 1'b1;
        end
      end else if (act_q) begin
        if (rem_q == PH_W'(1)) begin
          vref_q <= 1'b1;
          act_q  <= 1'b0;
        end else begin
          rem_q <= rem_q - PH_W'(1);
        end
      end
    end
  end

  assign vref_o = vref_q;

  AST_DELAY_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> rem_q != '0); // R4
endmodule

// File: rtl/phase_buildout.sv
module phase_buildout
  import phase_buildout_pkg::*;
#(
  parameter int PH_W        = 8,
  parameter int CLR_MIN_CYC = 38,
  parameter int TICK_CYC    = 15625,
  parameter int SLEW_STEP   = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_edge_i,
  input  logic            fb_edge_i,
  input  logic            switch_i,
  input  logic            enable_i,
  input  logic            clr_ni,
  output logic            vref_o,
  output logic [PH_W-1:0] offset_o
);
  localparam logic [PH_W-1:0] STEP_V = PH_W'(SLEW_STEP);

  logic [PH_W-1:0] meas, offset_q, off_nxt;
  logic            clr_hit, tick, arm_q, cap;
  upd_sel_e        upd_sel;

  pb_phase_meter #(.PH_W(PH_W)) u_meter (
    .clk_i, .rst_ni, .ref_edge_i, .fb_edge_i, .meas_o(meas)
  );

  pb_clear_filter #(.MIN_CYC(CLR_MIN_CYC)) u_clr (
    .clk_i, .rst_ni, .clr_ni, .hit_o(clr_hit)
  );

  pb_tick_gen #(.PERIOD(TICK_CYC)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  assign cap = ref_edge_i && arm_q && enable_i;

  always_comb begin
    if (clr_hit)                upd_sel = UPD_CLEAR;
    else if (cap)               upd_sel = UPD_CAPTURE;
    else if (tick && !enable_i) upd_sel = UPD_SLEW;
    else                        upd_sel = UPD_HOLD;
  end

  always_comb begin
    unique case (upd_sel)
      UPD_CLEAR:   off_nxt = '0;
      UPD_CAPTURE: off_nxt = meas;
      UPD_SLEW:    off_nxt = (offset_q > STEP_V) ? offset_q - STEP_V : '0;
      default:     off_nxt = offset_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= '0;
      arm_q    <= 1'b0;
    end else begin
      offset_q <= off_nxt;
      // the first reference edge after a switch consumes it, enabled or not
      arm_q    <= switch_i || (arm_q && !ref_edge_i);
    end
  end

  // delay uses the value that takes effect at this edge
  pb_vref_delay #(.PH_W(PH_W)) u_delay (
    .clk_i, .rst_ni, .ref_edge_i, .delay_i(off_nxt), .vref_o
  );

  assign offset_o = offset_q;

  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> offset_o == '0); // R5
  AST_CAPTURE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && !clr_hit) |=> offset_o == $past(meas)); // R2
  AST_SLEW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !clr_hit && !cap) |=>
      (offset_o <= $past(offset_o)) &&
      (int'(offset_o) + SLEW_STEP >= int'($past(offset_o)))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !clr_hit && !cap) |=> $stable(offset_o)); // R7
endmodule

// File: tb/phase_buildout_test.sv
module phase_buildout_test;
  localparam int PH_W    = 8;
  localparam int TB_CLR  = 6;
  localparam int TB_TICK = 1000;
  localparam int TB_STEP = 3;
  localparam int NVEC    = 7;
  // {ref-to-fb spacing, enable at capture, expected offset}
  localparam int VEC [NVEC][3] = '{
    '{5, 1, 5}, '{0, 1, 0}, '{12, 1, 12}, '{7, 0, 12},
    '{1, 1, 1}, '{300, 1, 255}, '{3, 1, 3}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_edge = 1'b0, fb_edge = 1'b0, sw = 1'b0, enable = 1'b1, clr_n = 1'b1;
  logic vref;
  logic [PH_W-1:0] offset;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  phase_buildout #(.PH_W(PH_W), .CLR_MIN_CYC(TB_CLR), .TICK_CYC(TB_TICK),
                   .SLEW_STEP(TB_STEP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_edge_i(ref_edge), .fb_edge_i(fb_edge),
    .switch_i(sw), .enable_i(enable), .clr_ni(clr_n),
    .vref_o(vref), .offset_o(offset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic f, input logic s);
    @(negedge clk);
    ref_edge = r; fb_edge = f; sw = s;
  endtask

  task automatic measure(input int d);
    step(1'b1, d == 0, 1'b0);
    if (d > 0) begin
      repeat (d - 1) step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
    end
    repeat (2) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_vec(input int d, input int en, input int exp);
    int first_hi, n_hi;
    measure(d);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    enable = en[0];
    step(1'b1, 1'b0, 1'b0);
    first_hi = -1; n_hi = 0;
    for (int i = 1; i <= exp + 3; i++) begin
      step(1'b0, 1'b0, 1'b0);
      if (i == 1) enable = 1'b1;
      if (vref) begin
        n_hi++;
        if (first_hi < 0) first_hi = i;
      end
    end
    // R1 R2 R3 R9: loaded value
    chk(offset == PH_W'(exp), "R1/R2/R3/R9 offset after switch", offset, exp);
    // R4: single pulse at D+1
    chk(n_hi == 1 && first_hi == exp + 1, "R4 vref position", first_hi, exp + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk(offset == '0, "R8 reset offset", offset, 0);
    chk(vref == 1'b0, "R8 reset vref", vref, 0);

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2]);

    // R2: edge without a new switch leaves offset alone
    measure(9);
    step(1'b1, 1'b0, 1'b0);
    repeat (3) step(1'b0, 1'b0, 1'b0);
    chk(offset == PH_W'(3), "R2 no switch no load", offset, 3);

    // R5: one cycle short of the minimum
    clr_n = 1'b0;
    repeat (TB_CLR - 1) step(1'b0, 1'b0, 1'b0);
    clr_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk(offset == PH_W'(3), "R5 short clear ignored", offset, 3);
    clr_n = 1'b0;
    repeat (TB_CLR) step(1'b0, 1'b0, 1'b0);
    clr_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk(offset == '0, "R5 full clear", offset, 0);

    // R6: decay over exact tick windows
    run_vec(20, 1, 20);
    enable = 1'b0;
    repeat (2 * TB_TICK) step(1'b0, 1'b0, 1'b0);
    chk(offset == PH_W'(20 - 2 * TB_STEP), "R6 slew two ticks", offset, 20 - 2 * TB_STEP);
    repeat (5 * TB_TICK) step(1'b0, 1'b0, 1'b0);
    chk(offset == '0, "R6 slew floor", offset, 0);
    enable = 1'b1;

    // R7: hold with enable high
    run_vec(40, 1, 40);
    repeat (3 * TB_TICK) step(1'b0, 1'b0, 1'b0);
    chk(offset == PH_W'(40), "R7 hold", offset, 40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule